// File: doc/BRIEF.md
# Early-Exit Pooled Classifier Head

This block turns the last feature map of a small image classifier into a class decision. After a start pulse it walks the feature memory one channel at a time and averages each channel over its spatial extent. The rounded channel averages then feed a small fully connected layer whose signed weights come from a weight ROM. The block reports the highest-scoring class.

The same engine serves two exit points, and a mode input chosen at start selects between them. Coarse mode reads an 8×8 map of 24 channels and scores three groups: normal scene, accident and natural hazard. If the coarse winner is the normal group, the early-exit flag tells the surrounding controller to skip the remaining layers. Fine mode reads a 2×2 map of 40 channels and scores five final classes.

Both memories are synchronous and return data on the cycle after the address is presented. Activations are unsigned 8-bit values with 2 integer bits and 6 fraction bits. Weights are signed 8-bit values with the same scaling.

Top module: `exit_head`

## Requirements
- R1: While reset is held and after it is released, `done`, `exit_early` and `class_idx` are all zero.
- R2: In coarse mode (`fine_mode`=0 at start), activation of channel c, pixel p (0..63) is read at feature address c*64+p for c in 0..23. The weight for class k and channel c is read at ROM address k*24+c. The class index reported is the argmax over the 3 coarse scores.
- R3: In fine mode (`fine_mode`=1 at start), activation of channel c, pixel p (0..3) is read at feature address c*4+p for c in 0..39. The weight for class k and channel c is read at ROM address 72+k*40+c. The class index reported is the argmax over the 5 fine scores.
- R4: Each channel average is the channel sum plus half of the pixel count, shifted right by 6 in coarse mode and by 2 in fine mode. A dropped fraction of exactly one half therefore rounds up.
- R5: Class scores are signed sums of average times weight, held wide enough that 40 products of 255 × (−128) or 255 × 127 neither wrap nor change sign.
- R6: When two or more classes share the highest score, the lowest class index is reported.
- R7: `exit_early` is 1 with `done` only when a coarse run selects class 0 (normal). It is 0 for coarse classes 1 (accident) and 2 (natural hazard) and for every fine run.
- R8: `done` is high for exactly one cycle per run. `class_idx` and `exit_early` change only in that cycle and keep their values until the next run completes.
- R9: A `start` pulse, or a change of `fine_mode`, while a run is in progress has no effect. The run completes in its original mode with a single `done`.
- R10: Class codes are as follows. Coarse mode: 0 normal, 1 accident, 2 natural hazard. Fine mode: 0 normal, 1 collapsed building, 2 traffic accident, 3 fire, 4 flood. No reported index exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when the block is idle |
| fine_mode | input | 1 | Sampled with start: 0 coarse, 1 fine |
| fmap_addr | output | 11 | Feature memory read address |
| fmap_data | input | 8 | Feature memory read data, one cycle after address |
| wrom_addr | output | 9 | Weight ROM read address |
| wrom_data | input | 8 | Signed weight ROM data, one cycle after address |
| class_idx | output | 3 | Winning class of the last completed run |
| exit_early | output | 1 | Coarse run selected the normal class |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that both memories return the addressed word exactly one cycle later. They also assume that feature and weight contents are laid out as R2 and R3 describe, and that `start` is seen only by an idle block. The bench meets these assumptions with registered array models clocked on the same edge as the block. It loads contents only between runs and applies stimulus only on the falling edge. Scores and averages are recomputed in the bench from the array contents and the rounding rule. The bench also places deliberate half-way sums, equal scores and extreme products to reach the rounding, tie and width corners.

// File: rtl/exit_head_pkg.sv
package exit_head_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POOL,
    ST_DRAIN,
    ST_DENSE,
    ST_WAIT
  } head_state_t;

  localparam logic MODE_COARSE = 1'b0;
  localparam logic MODE_FINE   = 1'b1;
endpackage

// File: rtl/exit_head_gap.sv
// Per-channel spatial averager: accumulates one channel, emits a rounded mean.
module exit_head_gap #(
  parameter int ACT_W = 8,
  parameter int SUM_W = 15,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic             in_last,
  input  logic [ACT_W-1:0] in_data,
  input  logic [SH_W-1:0]  sh,
  output logic             avg_v,
  output logic [ACT_W-1:0] avg
);
  logic [SUM_W-1:0] sum_q, sum_nx, half;
  logic [ACT_W-1:0] avg_nx;

  always_comb begin
    sum_nx = sum_q + SUM_W'(in_data);
    half   = SUM_W'(1) << (sh - SH_W'(1));
    avg_nx = ACT_W'((sum_nx + half) >> sh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      avg_v <= 1'b0;
      avg   <= '0;
    end else begin
      avg_v <= 1'b0;
      if (in_v) begin
        if (in_last) begin
          sum_q <= '0;
          avg   <= avg_nx;
          avg_v <= 1'b1;
        end else begin
          sum_q <= sum_nx;
        end
      end
    end
  end
endmodule

// File: rtl/exit_head_mac.sv
// Signed multiply-accumulate over one class row of the dense layer.
module exit_head_mac #(
  parameter int ACT_W = 8,
  parameter int W_W   = 8,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic                    in_last,
  input  logic [ACT_W-1:0]        act,
  input  logic signed [W_W-1:0]   wt,
  output logic                    score_v,
  output logic signed [ACC_W-1:0] score
);
  logic signed [ACT_W+W_W:0] prod;
  logic signed [ACC_W-1:0]   acc_q, acc_nx;

  always_comb begin
    prod   = $signed({1'b0, act}) * wt;
    acc_nx = acc_q + ACC_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      score_v <= 1'b0;
      score   <= '0;
    end else begin
      score_v <= 1'b0;
      if (in_v) begin
        if (in_last) begin
          acc_q   <= '0;
          score   <= acc_nx;
          score_v <= 1'b1;
        end else begin
          acc_q <= acc_nx;
        end
      end
    end
  end
endmodule

// File: rtl/exit_head_argmax.sv
// Running maximum over class scores; strict compare keeps the lowest index on ties.
module exit_head_argmax #(
  parameter int ACC_W = 24,
  parameter int CLS_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    s_v,
  input  logic signed [ACC_W-1:0] score,
  input  logic [CLS_W-1:0]        n_cls,
  output logic [CLS_W-1:0]        best_idx,
  output logic                    fin
);
  logic [CLS_W-1:0]        idx_q;
  logic signed [ACC_W-1:0] best_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      best_q   <= '0;
      best_idx <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (clr) begin
        idx_q <= '0;
      end else if (s_v) begin
        if (idx_q == '0 || score > best_q) begin
          best_q   <= score;
          best_idx <= idx_q;
        end
        idx_q <= idx_q + CLS_W'(1);
        fin   <= (idx_q == n_cls - CLS_W'(1));
      end
    end
  end
endmodule

// File: rtl/exit_head.sv
module exit_head
  import exit_head_pkg::*;
#(
  parameter int ACT_W  = 8,
  parameter int W_W    = 8,
  parameter int ACC_W  = 24,
  parameter int C_CH   = 24,
  parameter int C_LOG  = 6,
  parameter int C_CLS  = 3,
  parameter int F_CH   = 40,
  parameter int F_LOG  = 2,
  parameter int F_CLS  = 5,
  localparam int MAX_CH   = (C_CH > F_CH) ? C_CH : F_CH,
  localparam int MAX_CLS  = (C_CLS > F_CLS) ? C_CLS : F_CLS,
  localparam int MAX_LOG  = (C_LOG > F_LOG) ? C_LOG : F_LOG,
  localparam int C_WORDS  = C_CH << C_LOG,
  localparam int F_WORDS  = F_CH << F_LOG,
  localparam int FM_DEPTH = (C_WORDS > F_WORDS) ? C_WORDS : F_WORDS,
  localparam int WR_DEPTH = C_CH * C_CLS + F_CH * F_CLS,
  localparam int FM_AW    = $clog2(FM_DEPTH),
  localparam int WR_AW    = $clog2(WR_DEPTH),
  localparam int CLS_W    = $clog2(MAX_CLS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  fine_mode,
  output logic [FM_AW-1:0]      fmap_addr,
  input  logic [ACT_W-1:0]      fmap_data,
  output logic [WR_AW-1:0]      wrom_addr,
  input  logic signed [W_W-1:0] wrom_data,
  output logic [CLS_W-1:0]      class_idx,
  output logic                  exit_early,
  output logic                  done
);
  localparam int CH_W  = $clog2(MAX_CH + 1);
  localparam int PIX_W = MAX_LOG;
  localparam int SH_W  = $clog2(MAX_LOG + 1);
  localparam int SUM_W = ACT_W + MAX_LOG + 1;

  head_state_t st;
  logic        mode_q;
  logic        go;

  logic [CH_W-1:0]  ch_n;
  logic [CLS_W-1:0] cls_n;
  logic [PIX_W-1:0] pix_last;
  logic [SH_W-1:0]  sh;
  logic [WR_AW-1:0] w_base;

  logic [CH_W-1:0]  ch_c, wr_ch;
  logic [PIX_W-1:0] pix_c;
  logic [CLS_W-1:0] cls_c;
  logic             last_pix, last_ch, last_cls;

  logic d_pv, d_plast, d_dv, d_dlast;

  logic [ACT_W-1:0] avg_mem [MAX_CH];
  logic [ACT_W-1:0] act_q;
  logic             avg_v;
  logic [ACT_W-1:0] avg;

  logic                    score_v;
  logic signed [ACC_W-1:0] score;
  logic [CLS_W-1:0]        best_idx;
  logic                    fin;

  assign go = start && (st == ST_IDLE);

  always_comb begin
    if (mode_q == MODE_FINE) begin
      ch_n     = CH_W'(F_CH);
      cls_n    = CLS_W'(F_CLS);
      pix_last = PIX_W'((1 << F_LOG) - 1);
      sh       = SH_W'(F_LOG);
      w_base   = WR_AW'(C_CH * C_CLS);
    end else begin
      ch_n     = CH_W'(C_CH);
      cls_n    = CLS_W'(C_CLS);
      pix_last = PIX_W'((1 << C_LOG) - 1);
      sh       = SH_W'(C_LOG);
      w_base   = '0;
    end
    last_pix = (pix_c == pix_last);
    last_ch  = (ch_c == ch_n - CH_W'(1));
    last_cls = (cls_c == cls_n - CLS_W'(1));
  end

  // Sequencer: pooling sweep, drain of the averager, dense sweep, argmax wait.
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mode_q     <= MODE_COARSE;
      ch_c       <= '0;
      pix_c      <= '0;
      cls_c      <= '0;
      fmap_addr  <= '0;
      wrom_addr  <= '0;
      class_idx  <= '0;
      exit_early <= 1'b0;
      done       <= 1'b0;
      d_pv       <= 1'b0;
      d_plast    <= 1'b0;
      d_dv       <= 1'b0;
      d_dlast    <= 1'b0;
    end else begin
      done    <= 1'b0;
      d_pv    <= (st == ST_POOL);
      d_plast <= (st == ST_POOL) && last_pix;
      d_dv    <= (st == ST_DENSE);
      d_dlast <= (st == ST_DENSE) && last_ch;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= fine_mode;
            st        <= ST_POOL;
            fmap_addr <= '0;
            ch_c      <= '0;
            pix_c     <= '0;
          end
        end
        ST_POOL: begin
          if (last_pix && last_ch) begin
            st    <= ST_DRAIN;
            pix_c <= '0;
          end else begin
            fmap_addr <= fmap_addr + FM_AW'(1);
            if (last_pix) begin
              pix_c <= '0;
              ch_c  <= ch_c + CH_W'(1);
            end else begin
              pix_c <= pix_c + PIX_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (wr_ch == ch_n) begin
            st        <= ST_DENSE;
            ch_c      <= '0;
            cls_c     <= '0;
            wrom_addr <= w_base;
          end
        end
        ST_DENSE: begin
          if (last_ch && last_cls) begin
            st <= ST_WAIT;
          end else begin
            wrom_addr <= wrom_addr + WR_AW'(1);
            if (last_ch) begin
              ch_c  <= '0;
              cls_c <= cls_c + CLS_W'(1);
            end else begin
              ch_c <= ch_c + CH_W'(1);
            end
          end
        end
        ST_WAIT: begin
          if (fin) begin
            class_idx  <= best_idx;
            exit_early <= (mode_q == MODE_COARSE) && (best_idx == '0);
            done       <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Channel-average store: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (avg_v) avg_mem[wr_ch] <= avg;
    act_q <= avg_mem[ch_c];
  end

  always_ff @(posedge clk) begin
    if (rst || go) wr_ch <= '0;
    else if (avg_v) wr_ch <= wr_ch + CH_W'(1);
  end

  exit_head_gap #(.ACT_W(ACT_W), .SUM_W(SUM_W), .SH_W(SH_W)) u_gap (
    .clk(clk), .rst(rst), .in_v(d_pv), .in_last(d_plast),
    .in_data(fmap_data), .sh(sh), .avg_v(avg_v), .avg(avg)
  );

  exit_head_mac #(.ACT_W(ACT_W), .W_W(W_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .in_v(d_dv), .in_last(d_dlast),
    .act(act_q), .wt(wrom_data), .score_v(score_v), .score(score)
  );

  exit_head_argmax #(.ACC_W(ACC_W), .CLS_W(CLS_W)) u_arg (
    .clk(clk), .rst(rst), .clr(go), .s_v(score_v), .score(score),
    .n_cls(cls_n), .best_idx(best_idx), .fin(fin)
  );
endmodule

// File: rtl/exit_head_chk.sv
module exit_head_chk #(
  parameter int FM_DEPTH = 1536,
  parameter int WR_DEPTH = 272,
  parameter int FM_AW    = 11,
  parameter int WR_AW    = 9,
  parameter int CLS_W    = 3,
  parameter int F_CLS    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             exit_early,
  input logic [CLS_W-1:0] class_idx,
  input logic [FM_AW-1:0] fmap_addr,
  input logic [WR_AW-1:0] wrom_addr
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (done || ($stable(class_idx) && $stable(exit_early))));

  // R7
  exit_normal_chk: assert property (@(posedge clk) disable iff (rst)
    exit_early |-> (class_idx == '0));

  // R10
  class_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(class_idx) < F_CLS));

  // R2
  fmap_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fmap_addr) < FM_DEPTH);

  // R3
  wrom_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(wrom_addr) < WR_DEPTH);
endmodule

bind exit_head exit_head_chk #(
  .FM_DEPTH(FM_DEPTH), .WR_DEPTH(WR_DEPTH), .FM_AW(FM_AW),
  .WR_AW(WR_AW), .CLS_W(CLS_W), .F_CLS(F_CLS)
) u_chk (
  .clk(clk), .rst(rst), .done(done), .exit_early(exit_early),
  .class_idx(class_idx), .fmap_addr(fmap_addr), .wrom_addr(wrom_addr)
);

// File: tb/exit_head_test.sv
`timescale 1ns/1ps
module exit_head_test;
  localparam int PERIOD = 10;
  localparam int FMD    = 1536;
  localparam int WRD    = 272;
  localparam int FINE_W = 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic fine_mode = 1'b0;
  logic [10:0] fmap_addr;
  logic [7:0]  fmap_data;
  logic [8:0]  wrom_addr;
  logic signed [7:0] wrom_data;
  logic [2:0]  class_idx;
  logic        exit_early;
  logic        done;

  logic [7:0]        fmem [FMD];
  logic signed [7:0] wmem [WRD];

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    fmap_data <= fmem[fmap_addr];
    wrom_data <= wmem[wrom_addr];
  end

  exit_head uut (
    .clk(clk), .rst(rst), .start(start), .fine_mode(fine_mode),
    .fmap_addr(fmap_addr), .fmap_data(fmap_data),
    .wrom_addr(wrom_addr), .wrom_data(wrom_data),
    .class_idx(class_idx), .exit_early(exit_early), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int widx(input bit fine, input int k, input int c);
    return fine ? (FINE_W + k * 40 + c) : (k * 24 + c);
  endfunction

  // Reference from R2..R6: rounded means, signed dot products, lowest index on ties.
  function automatic int ref_class(input bit fine);
    int nch, lg, ncls, best, bidx;
    int avgs [40];
    nch  = fine ? 40 : 24;
    lg   = fine ? 2 : 6;
    ncls = fine ? 5 : 3;
    for (int c = 0; c < nch; c++) begin
      int s = 0;
      for (int p = 0; p < (1 << lg); p++) s += int'(fmem[(c << lg) + p]);
      avgs[c] = (s + (1 << (lg - 1))) >> lg;
    end
    best = 0;
    bidx = 0;
    for (int k = 0; k < ncls; k++) begin
      int sc = 0;
      for (int c = 0; c < nch; c++) sc += avgs[c] * int'(wmem[widx(fine, k, c)]);
      if (k == 0 || sc > best) begin
        best = sc;
        bidx = k;
      end
    end
    return bidx;
  endfunction

  task automatic clear_mems();
    for (int i = 0; i < FMD; i++) fmem[i] = 8'd0;
    for (int i = 0; i < WRD; i++) wmem[i] = 8'sd0;
  endtask

  task automatic fill(input int seed, input bit fine, input int target);
    for (int i = 0; i < FMD; i++) fmem[i] = 8'((i * 37 + seed * 11) % 97);
    for (int i = 0; i < WRD; i++) wmem[i] = 8'(((i * 13 + seed * 7) % 15) - 7);
    for (int c = 0; c < (fine ? 40 : 24); c++) wmem[widx(fine, target, c)] = 8'sd64;
  endtask

  task automatic run_head(input bit fine, output int cls, output bit ex, output int ndone);
    ndone = 0;
    cls = -1;
    ex = 1'b0;
    @(negedge clk);
    start = 1'b1;
    fine_mode = fine;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000 && ndone == 0; i++) begin
      @(negedge clk);
      if (done) begin
        ndone++;
        cls = int'(class_idx);
        ex = exit_early;
      end
    end
    if (ndone == 0) check(1'b0, "R8 no done", 0, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) ndone++;
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(exit_early == 1'b0, "R1 exit", int'(exit_early), 0);
    check(class_idx == 3'd0, "R1 class", int'(class_idx), 0);
  endtask

  task automatic t_coarse(input int seed, input int target);
    int cls, nd, exp;
    bit ex;
    fill(seed, 1'b0, target);
    exp = ref_class(1'b0);
    run_head(1'b0, cls, ex, nd);
    check(cls == exp, "R2 coarse class", cls, exp);
    check(ex == (exp == 0), "R7 coarse exit", int'(ex), int'(exp == 0));
    check(nd == 1, "R8 single done", nd, 1);
  endtask

  task automatic t_fine(input int seed, input int target);
    int cls, nd, exp;
    bit ex;
    fill(seed, 1'b1, target);
    exp = ref_class(1'b1);
    run_head(1'b1, cls, ex, nd);
    check(cls == exp, "R3 fine class", cls, exp);
    check(ex == 1'b0, "R7 fine no exit", int'(ex), 0);
    check(nd == 1, "R8 single done", nd, 1);
  endtask

  task automatic t_round();
    int cls, nd;
    bit ex;
    clear_mems();
    wmem[widx(1'b0, 1, 0)] = 8'sd1;
    for (int p = 0; p < 32; p++) fmem[p] = 8'd1;
    run_head(1'b0, cls, ex, nd);
    check(cls == 1, "R4 coarse half rounds up", cls, 1);
    fmem[31] = 8'd0;
    run_head(1'b0, cls, ex, nd);
    check(cls == 0, "R4 coarse below half", cls, 0);
    clear_mems();
    wmem[widx(1'b1, 2, 0)] = 8'sd1;
    fmem[0] = 8'd1;
    fmem[1] = 8'd1;
    run_head(1'b1, cls, ex, nd);
    check(cls == 2, "R4 fine half rounds up", cls, 2);
    fmem[1] = 8'd0;
    run_head(1'b1, cls, ex, nd);
    check(cls == 0, "R4 fine below half", cls, 0);
  endtask

  task automatic t_tie();
    int cls, nd;
    bit ex;
    fill(5, 1'b0, 0);
    for (int i = 0; i < WRD; i++) wmem[i] = 8'sd0;
    run_head(1'b0, cls, ex, nd);
    check(cls == 0, "R6 all equal", cls, 0);
    check(ex == 1'b1, "R7 tie to normal exits", int'(ex), 1);
    for (int c = 0; c < 24; c++) begin
      wmem[widx(1'b0, 1, c)] = 8'sd3;
      wmem[widx(1'b0, 2, c)] = 8'sd3;
    end
    run_head(1'b0, cls, ex, nd);
    check(cls == 1, "R6 coarse tie 1 vs 2", cls, 1);
    fill(6, 1'b1, 0);
    for (int i = 0; i < WRD; i++) wmem[i] = -8'sd1;
    for (int c = 0; c < 40; c++) begin
      wmem[widx(1'b1, 3, c)] = 8'sd5;
      wmem[widx(1'b1, 4, c)] = 8'sd5;
    end
    run_head(1'b1, cls, ex, nd);
    check(cls == 3, "R6 fine tie 3 vs 4", cls, 3);
  endtask

  task automatic t_wide();
    int cls, nd;
    bit ex;
    for (int i = 0; i < FMD; i++) fmem[i] = 8'd255;
    for (int i = 0; i < WRD; i++) wmem[i] = -8'sd128;
    for (int c = 0; c < 40; c++) wmem[widx(1'b1, 1, c)] = 8'sd127;
    run_head(1'b1, cls, ex, nd);
    check(cls == 1, "R5 fine extreme positive", cls, 1);
    for (int c = 0; c < 40; c++) begin
      wmem[widx(1'b1, 1, c)] = -8'sd128;
      wmem[widx(1'b1, 3, c)] = -8'sd1;
    end
    run_head(1'b1, cls, ex, nd);
    check(cls == 3, "R5 all negative scores", cls, 3);
    for (int c = 0; c < 24; c++) wmem[widx(1'b0, 2, c)] = 8'sd127;
    run_head(1'b0, cls, ex, nd);
    check(cls == 2, "R5 coarse extreme", cls, 2);
    check(ex == 1'b0, "R7 hazard no exit", int'(ex), 0);
  endtask

  task automatic t_busy();
    int cls, nd, exp;
    cls = -1;
    nd = 0;
    fill(9, 1'b0, 1);
    exp = ref_class(1'b0);
    @(negedge clk);
    start = 1'b1;
    fine_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 100; i++) @(negedge clk);
    start = 1'b1;
    fine_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin
        nd++;
        if (nd == 1) cls = int'(class_idx);
      end
    end
    check(cls == exp, "R9 mid-run start ignored", cls, exp);
    check(nd == 1, "R9 one done", nd, 1);
    fine_mode = 1'b0;
  endtask

  task automatic t_hold();
    int cls, nd;
    bit ex;
    fill(11, 1'b0, 0);
    run_head(1'b0, cls, ex, nd);
    fill(12, 1'b1, 4);
    for (int i = 0; i < 50; i++) @(negedge clk);
    check(int'(class_idx) == cls, "R8 class held", int'(class_idx), cls);
    check(exit_early == ex, "R8 exit held", int'(exit_early), int'(ex));
    run_head(1'b1, cls, ex, nd);
    check(cls == 4, "R10 fine flood code", cls, 4);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_mems();
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_coarse(1, 0);
    t_coarse(2, 1);
    t_coarse(3, 2);
    t_fine(4, 0);
    t_fine(5, 3);
    t_fine(7, 2);
    t_round();
    t_tie();
    t_wide();
    t_busy();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule